// File: doc/BRIEF.md
# Oversampling Serial Receiver with Per-Character Error Queue

This block turns an asynchronous serial line back into parallel characters. A strobe that pulses sixteen times per bit period times the line. The line first passes through a two-stage synchronizer. A start bit is accepted only if the line is still low at the eighth strobe after the falling edge. After that, the data bits, the optional parity bit and the stop bit(s) are sampled every sixteen strobes, so each sample falls near the middle of its bit.

Each finished character goes into a 16-entry queue together with three status bits: parity mismatch, framing fault and break. The oldest entry is always visible on the read port. A read strobe removes it. A ready flag shows that the queue is not empty. A separate sticky flag reports characters that were lost because the queue was full. Software clears this flag with an acknowledge pulse.

The character format is set by three static inputs: data length from 5 to 8 bits, parity mode, and one or two stop bits.

Top module: `uart_rx_errfifo`

## Requirements
- R1: After reset, `data_ready` and `overrun` are both 0.
- R2: Data bits arrive LSB first and are stored in the order received. `cfg_len` selects the data length: 0 = 5, 1 = 6, 2 = 7, 3 = 8 bits.
- R3: For lengths below 8 bits, the unused upper bits of `rd_data` read as 0.
- R4: `cfg_par` of 2'b10 selects even parity and 2'b11 selects odd parity. `rd_perr` is 1 exactly when the received parity bit does not give the selected parity over the data bits.
- R5: When `cfg_par[1]` is 0, no parity bit is expected and `rd_perr` reads 0.
- R6: If the first stop bit is sampled low and the character is not a break, the entry keeps its data with `rd_ferr` = 1. The receiver then waits for the line to go high before it looks for a new start bit.
- R7: A low pulse that ends before the eighth strobe after the falling edge produces no entry.
- R8: A break is a line held low through every sampled bit, including all configured stop bits. It stores exactly one entry with data 0, `rd_brk` = 1, `rd_perr` = 0 and `rd_ferr` = 0. No further entry is stored until the line has returned high.
- R9: The queue holds 16 entries and returns them in arrival order. `data_ready` is 1 exactly when at least one entry is stored, and a `rd_en` pulse removes the oldest entry.
- R10: A character that completes while the queue is full is discarded, the queue contents stay intact, and `overrun` is set. `overrun` stays 1 until an `ovr_ack` pulse clears it.
- R11: With two stop bits selected (`cfg_stop` = 1), an all-zero character whose second stop bit is high is stored as a framing fault (data 0, `rd_ferr` = 1, `rd_brk` = 0), not as a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| tick16 | input | 1 | One-cycle strobe at sixteen times the bit rate |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_par | input | 2 | Parity: 0x none, 10 even, 11 odd |
| cfg_stop | input | 1 | 0 = one stop bit, 1 = two stop bits |
| rd_en | input | 1 | Remove the oldest queue entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_perr | output | 1 | Parity fault of the oldest entry |
| rd_ferr | output | 1 | Framing fault of the oldest entry |
| rd_brk | output | 1 | Break flag of the oldest entry |
| data_ready | output | 1 | Queue holds at least one entry |
| overrun | output | 1 | Sticky lost-character flag |
| ovr_ack | input | 1 | Clears `overrun` |

## Verification
The hardest situation to reach is a character that completes while the queue is already full. The stimulus gets there by sending seventeen back-to-back frames with no reads at all. It then drains the queue and confirms that the seventeenth frame was dropped while the first sixteen came back in order. A second hard case is an all-zero frame in two-stop mode whose second stop bit is high. Only the receiver's choice between break and framing fault tells that frame apart from a real break, so the bench drives one of each and compares the stored status bits.

// File: rtl/rx_pkg.sv
// Shared types for the oversampling serial receiver.
package rx_pkg;
    localparam int RX_DATA_W = 8;

    // One queue entry: status bits above the data byte.
    typedef struct packed {
        logic                 brk;
        logic                 ferr;
        logic                 perr;
        logic [RX_DATA_W-1:0] data;
    } rx_entry_t;

    localparam int RX_ENTRY_W = $bits(rx_entry_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2,
        ST_WAIT_HI
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
// Multi-stage synchronizer for the asynchronous serial input.
// Assumes: the input is idle high, so the stages reset to RESET_VAL.
module rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rx_deser.sv
// Character deserializer. It confirms the start bit at mid-bit, samples the
// data, parity and stop bits every OVS strobes, and classifies each character
// as good, parity fault, framing fault or break.
// Assumes: rx_s is already synchronous; the cfg_* inputs stay static while a
// character is being received.
module rx_deser
    import rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx_s,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic      cfg_stop,
    output logic      out_vld,
    output rx_entry_t out_ent
);
    localparam int           CW   = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam int           IW   = $clog2(RX_DATA_W);

    rx_state_e            state;
    logic [CW-1:0]        cnt;
    logic [IW-1:0]        bit_idx;
    logic [RX_DATA_W-1:0] shreg;
    logic                 perr_q;
    logic                 allzero;
    logic [IW-1:0]        last_idx;
    logic                 at_sample;

    // Index of the final data bit for the chosen length (5..8 bits).
    assign last_idx  = IW'(4) + IW'(cfg_len);
    assign at_sample = tick && (cnt == LAST);

    // Receive state machine: start check, sampling and classification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            perr_q  <= 1'b0;
            allzero <= 1'b0;
            out_vld <= 1'b0;
            out_ent <= '0;
        end else begin
            out_vld <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rx_s) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (rx_s) begin
                            state <= ST_IDLE;
                        end else if (cnt == MID) begin
                            state   <= ST_DATA;
                            cnt     <= '0;
                            bit_idx <= '0;
                            shreg   <= '0;
                            perr_q  <= 1'b0;
                            allzero <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_sample) begin
                            cnt            <= '0;
                            shreg[bit_idx] <= rx_s;
                            if (rx_s) allzero <= 1'b0;
                            if (bit_idx == last_idx)
                                state <= cfg_par[1] ? ST_PAR : ST_STOP1;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_sample) begin
                            cnt    <= '0;
                            perr_q <= (^shreg) ^ rx_s ^ cfg_par[0];
                            if (rx_s) allzero <= 1'b0;
                            state  <= ST_STOP1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP1: begin
                        if (at_sample) begin
                            cnt <= '0;
                            if (rx_s) begin
                                out_vld <= 1'b1;
                                out_ent <= '{brk: 1'b0, ferr: 1'b0, perr: perr_q, data: shreg};
                                state   <= ST_IDLE;
                            end else if (allzero && cfg_stop) begin
                                state <= ST_STOP2;
                            end else if (allzero) begin
                                out_vld <= 1'b1;
                                out_ent <= '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: '0};
                                state   <= ST_WAIT_HI;
                            end else begin
                                out_vld <= 1'b1;
                                out_ent <= '{brk: 1'b0, ferr: 1'b1, perr: perr_q, data: shreg};
                                state   <= ST_WAIT_HI;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (at_sample) begin
                            cnt     <= '0;
                            out_vld <= 1'b1;
                            if (rx_s) begin
                                out_ent <= '{brk: 1'b0, ferr: 1'b1, perr: perr_q, data: shreg};
                                state   <= ST_IDLE;
                            end else begin
                                out_ent <= '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: '0};
                                state   <= ST_WAIT_HI;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WAIT_HI: begin
                        if (rx_s) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R7: a high sample during the start check returns to idle.
    p_false_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick && rx_s) |=> (state == ST_IDLE));

    // R8: after a break entry, reception holds off until the line is high.
    p_break_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_ent.brk) |-> (state == ST_WAIT_HI));

    // R8: at most one entry per character.
    p_single_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);
endmodule

// File: rtl/rx_fifo.sv
// Synchronous queue with first-word fall-through. The head entry is always
// visible; pop removes it.
// Assumes: the caller never pushes when full or pops when empty.
module rx_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic [AW:0]  level;

    // Write storage; the data needs no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wp[AW-1:0]] <= wdata;
    end

    // Advance the read and write pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    assign level = wp - rp;
    assign full  = (level == (AW+1)'(DEPTH));
    assign empty = (level == '0);
    assign head  = mem[rp[AW-1:0]];

    // R10: never write into a full queue.
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9: never read from an empty queue.
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R9: a push without a pop leaves the queue non-empty.
    p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty);
endmodule

// File: rtl/uart_rx_errfifo.sv
// Top level: synchronizer, deserializer and the status queue, plus the sticky
// overrun flag.
// Assumes: tick16 is a single-cycle strobe at sixteen times the bit rate.
module uart_rx_errfifo
    import rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_serial,
    input  logic       tick16,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       cfg_stop,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       data_ready,
    output logic       overrun,
    input  logic       ovr_ack
);
    logic      rx_s;
    logic      ch_vld;
    rx_entry_t ch_ent;
    rx_entry_t head;
    logic      q_full, q_empty, q_push, q_pop;

    rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(rx_serial), .q_sync(rx_s)
    );

    rx_deser #(.OVS(OVS)) u_deser (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
        .out_vld(ch_vld), .out_ent(ch_ent)
    );

    assign q_push = ch_vld && !q_full;
    assign q_pop  = rd_en && !q_empty;

    rx_fifo #(.W(RX_ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(q_push), .wdata(ch_ent),
        .pop(q_pop), .head(head), .full(q_full), .empty(q_empty)
    );

    // Set on a dropped character; cleared only by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  overrun <= 1'b0;
        else if (ch_vld && q_full)   overrun <= 1'b1;
        else if (ovr_ack)            overrun <= 1'b0;
    end

    assign rd_data    = head.data;
    assign rd_perr    = head.perr;
    assign rd_ferr    = head.ferr;
    assign rd_brk     = head.brk;
    assign data_ready = !q_empty;

    // R10: overrun stays set until acknowledged.
    p_ovr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_ack) |=> overrun);

    // R10: a character finishing into a full queue raises overrun.
    p_ovr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_vld && q_full) |=> overrun);

    // R1: the flags read 0 on the cycle after reset.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!data_ready && !overrun));
endmodule

// File: tb/sim_uart_rx_errfifo.sv
module sim_uart_rx_errfifo;
    localparam int BIT = 32; // 16 strobes, one every 2 clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_serial = 1'b1;
    logic tphase = 1'b0;
    logic tick16;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic cfg_stop = 1'b0;
    logic rd_en = 1'b0;
    logic ovr_ack = 1'b0;
    logic [7:0] rd_data;
    logic rd_perr, rd_ferr, rd_brk, data_ready, overrun;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) tphase <= ~tphase;
    assign tick16 = tphase;

    uart_rx_errfifo u0 (
        .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial), .tick16(tick16),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
        .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .rd_brk(rd_brk), .data_ready(data_ready),
        .overrun(overrun), .ovr_ack(ovr_ack)
    );

    // {len[2], par[2], stop, data[8], badpar, stoplow, exp_data[8], exp_pe, exp_fe}
    localparam logic [24:0] VEC [8] = '{
        {2'd3, 2'b00, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
        {2'd3, 2'b10, 1'b0, 8'h37, 1'b0, 1'b0, 8'h37, 1'b0, 1'b0},
        {2'd3, 2'b11, 1'b0, 8'h37, 1'b1, 1'b0, 8'h37, 1'b1, 1'b0},
        {2'd0, 2'b00, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
        {2'd1, 2'b10, 1'b1, 8'h2A, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0},
        {2'd2, 2'b11, 1'b0, 8'h55, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
        {2'd3, 2'b00, 1'b0, 8'hC3, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b1},
        {2'd2, 2'b10, 1'b1, 8'h7F, 1'b1, 1'b0, 8'h7F, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic line(input logic v, input int clocks);
        rx_serial = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic bad, input logic slow);
        logic [7:0] m;
        m = d & ((8'd1 << (5 + cfg_len)) - 8'd1);
        line(1'b0, BIT);
        for (int i = 0; i < 5 + int'(cfg_len); i++) line(m[i], BIT);
        if (cfg_par[1]) line((^m) ^ cfg_par[0] ^ bad, BIT);
        line(~slow, BIT);
        if (cfg_stop) line(1'b1, BIT);
        rx_serial = 1'b1;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 data_ready", data_ready, 0);
        check("R1 overrun", overrun, 0);
        line(1'b1, BIT);

        // Vector table: R2 R3 R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            cfg_len  = VEC[i][24:23];
            cfg_par  = VEC[i][22:21];
            cfg_stop = VEC[i][20];
            send(VEC[i][19:12], VEC[i][11], VEC[i][10]);
            line(1'b1, 2 * BIT);
            check("R9 ready after char", data_ready, 1);
            check("R2/R3 data", rd_data, VEC[i][9:2]);
            check("R4/R5 perr", rd_perr, VEC[i][1]);
            check("R6 ferr", rd_ferr, VEC[i][0]);
            check("R2 brk clear", rd_brk, 0);
            pop();
            check("R9 empty after pop", data_ready, 0);
        end

        // R7: short low pulse is rejected
        cfg_len = 2'd3; cfg_par = 2'b00; cfg_stop = 1'b0;
        line(1'b0, 6);
        line(1'b1, 3 * BIT);
        check("R7 false start no entry", data_ready, 0);

        // R8: break in 8N1, then a normal character
        line(1'b0, 14 * BIT);
        check("R8 break stored", data_ready, 1);
        check("R8 break bit", rd_brk, 1);
        check("R8 break data", rd_data, 0);
        check("R8 break ferr", rd_ferr, 0);
        check("R8 break perr", rd_perr, 0);
        pop();
        line(1'b0, 4 * BIT);
        check("R8 single entry while low", data_ready, 0);
        line(1'b1, 2 * BIT);
        send(8'h5A, 1'b0, 1'b0);
        line(1'b1, 2 * BIT);
        check("R8 char after break", rd_data, 8'h5A);
        pop();

        // R11: two stops, all zero, second stop high -> framing fault
        cfg_stop = 1'b1;
        send(8'h00, 1'b0, 1'b1);
        line(1'b1, 2 * BIT);
        check("R11 entry", data_ready, 1);
        check("R11 ferr", rd_ferr, 1);
        check("R11 not break", rd_brk, 0);
        check("R11 data", rd_data, 0);
        pop();
        line(1'b0, 14 * BIT);
        line(1'b1, 2 * BIT);
        check("R11 full break", rd_brk, 1);
        pop();
        cfg_stop = 1'b0;

        // R9 / R10: seventeen frames without reading
        for (int k = 1; k <= 17; k++) send(8'(k), 1'b0, 1'b0);
        line(1'b1, 2 * BIT);
        check("R10 overrun set", overrun, 1);
        for (int k = 1; k <= 16; k++) begin
            check("R9 order", rd_data, 32'(k));
            pop();
        end
        check("R10 seventeenth dropped", data_ready, 0);
        check("R10 overrun sticky", overrun, 1);
        ovr_ack = 1'b1;
        @(negedge clk);
        ovr_ack = 1'b0;
        @(negedge clk);
        check("R10 overrun cleared", overrun, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule